// File: doc/BRIEF.md
# Host Microcontroller Command/Data Port

This block connects a peripheral core to an external microcontroller that treats it as a memory device with two locations. The host uses an 8-bit data bus, a chip select, read and write strobes, an address-latch-enable line and one address line. The selected location decides whether an access is a command phase or a data phase. A completed write to the command location is passed to the core as a command byte on a one-cycle strobe. A completed write to the data location is passed on a separate one-cycle data strobe. A completed read of the data location raises a one-cycle read-advance strobe so that the core can present its next byte.

All host pins are asynchronous to the core clock. They pass together through one synchronizer pipeline, so the data byte, the select and chip select are all sampled in the same cycle as the strobe edge they belong to. The port works in one of two modes:
- **Separate bus:** the host holds ALE low. The address pin selects the phase.
- **Multiplexed bus:** when ALE falls, bit 0 of the data bus is stored as the phase select for the accesses that follow. Any address byte that appears on the data lines without a write strobe is ignored.

The data pads are split into input, output and output-enable signals. The active-low interrupt line follows the core's request signal.

Top module: `host_cmd_port`

## Requirements
- R1: The phase select value 0 addresses the command location and 1 addresses the data location. No other location exists.
- R2: A rising edge of wr_ni while cs_ni is low and the phase select is 0 produces exactly one cycle of cmd_wr_o. wr_byte_o then holds the data byte that was present while wr_ni was low. cmd_wr_o rises on the third clock edge after wr_ni rises.
- R3: A rising edge of wr_ni while cs_ni is low and the phase select is 1 produces exactly one cycle of data_wr_o, with the byte on wr_byte_o. No cmd_wr_o pulse occurs.
- R4: A write strobe given while cs_ni is high produces no cmd_wr_o pulse, no data_wr_o pulse and no change of wr_byte_o.
- R5: data_oe_o is high exactly while cs_ni and rd_ni are both low. While it is high, data_o equals rd_data_i.
- R6: A rising edge of rd_ni while cs_ni is low produces exactly one cycle of data_rd_o when the phase select is 1, and no pulse when it is 0.
- R7: While ALE has stayed low since reset, the phase select is taken from a0_i, sampled while the strobe was low.
- R8: Once ALE has been high after reset, the port stays in multiplexed mode until the next reset. Each falling edge of ALE stores data_i bit 0 as the phase select, and a0_i is ignored from then on.
- R9: int_no is the inverse of irq_i, delayed by one clock.
- R10: During reset, int_no is high and cmd_wr_o, data_wr_o and data_rd_o are low.
- R11: A read strobe given while cs_ni is high leaves data_oe_o low and produces no data_rd_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| ale_i | input | 1 | Address latch enable; held low for a separate bus |
| a0_i | input | 1 | Phase select pin for separate-bus mode |
| data_i | input | DATA_W | Data pad input |
| data_o | output | DATA_W | Data pad output value |
| data_oe_o | output | 1 | Data pad output enable |
| rd_data_i | input | DATA_W | Byte supplied by the core for host reads |
| irq_i | input | 1 | Interrupt request from the core |
| int_no | output | 1 | Interrupt to host, active low |
| cmd_wr_o | output | 1 | One-cycle strobe for a command byte |
| data_wr_o | output | 1 | One-cycle strobe for a data byte |
| wr_byte_o | output | DATA_W | Byte captured by the last accepted write |
| data_rd_o | output | 1 | One-cycle strobe after a data-location read |

## Verification
The bench changes the data byte and the chip select right after the write strobe rises. A design that sampled either value one stage late would report the wrong byte or drop the write.

In separate-bus mode, the bench toggles the address pin while deselected strobes are given. A decoder that did not gate on chip select would emit spurious command or data pulses.

The multiplexed test has two halves. First it drives an address byte that selects the data location while a0_i points at the command location. Then it drives the opposite combination. A design that kept using the pin after ALE activity, or that latched the wrong bit, sends the byte to the wrong strobe.

Strobe pulse counts expose any design that holds a pulse for more than one cycle.

// File: rtl/host_cmd_port_pkg.sv
package host_cmd_port_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  localparam int unsigned CTRL_PINS = 5;  // a0, cs, wr, rd, ale
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,    // synchronized
  output logic [W-1:0] q_d_o   // one cycle older, for edge detect
);
  logic [STAGES:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {(STAGES+1){RST_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-1:0], d_i};
    end
  end

  assign q_o   = stg_q[STAGES-1];
  assign q_d_o = stg_q[STAGES];
endmodule

// File: rtl/hcp_phase_sel.sv
module hcp_phase_sel
  import host_cmd_port_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ale_q_i,
  input  logic   ale_d_i,
  input  logic   d0_q_i,
  input  logic   a0_d_i,
  output phase_e phase_o,
  output logic   mux_mode_o
);
  phase_e lat_q;
  logic   mux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q <= 1'b0;
      lat_q <= PH_CMD;
    end else begin
      if (ale_q_i) mux_q <= 1'b1;
      // falling ALE: bit 0 of the address byte picks the phase
      if (ale_d_i && !ale_q_i) lat_q <= phase_e'(d0_q_i);
    end
  end

  assign mux_mode_o = mux_q;
  assign phase_o    = mux_q ? lat_q : phase_e'(a0_d_i);
endmodule

// File: rtl/hcp_strobe_dec.sv
module hcp_strobe_dec
  import host_cmd_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_q_i,
  input  logic              wr_d_i,
  input  logic              rd_q_i,
  input  logic              rd_d_i,
  input  logic              cs_d_i,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] data_d_i,
  output logic              cmd_wr_o,
  output logic              data_wr_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              data_rd_o
);
  logic wr_done, rd_done;

  // strobe release while selected; cs/data taken from the last low sample
  assign wr_done = wr_q_i && !wr_d_i && !cs_d_i;
  assign rd_done = rd_q_i && !rd_d_i && !cs_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_wr_o  <= 1'b0;
      data_wr_o <= 1'b0;
      data_rd_o <= 1'b0;
      wr_byte_o <= '0;
    end else begin
      cmd_wr_o  <= wr_done && (phase_i == PH_CMD);
      data_wr_o <= wr_done && (phase_i == PH_DATA);
      data_rd_o <= rd_done && (phase_i == PH_DATA);
      if (wr_done) wr_byte_o <= data_d_i;
    end
  end
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import host_cmd_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              ale_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              irq_i,
  output logic              int_no,
  output logic              cmd_wr_o,
  output logic              data_wr_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              data_rd_o
);
  localparam int unsigned PIN_W = DATA_W + CTRL_PINS;
  // idle levels: ale 0, rd/wr/cs 1, a0 0, data 0
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {DATA_W{1'b0}}};

  logic [PIN_W-1:0] pin_raw, pin_q, pin_d;
  logic             ale_q, ale_d, rd_q, rd_d, wr_q, wr_d, cs_d, a0_d;
  logic [DATA_W-1:0] data_q, data_d;
  phase_e           phase;
  logic             mux_mode;
  logic             int_q;

  assign pin_raw = {ale_i, rd_ni, wr_ni, cs_ni, a0_i, data_i};

  hcp_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_q),
    .q_d_o (pin_d)
  );

  assign {ale_q, rd_q, wr_q} = pin_q[PIN_W-1 -: 3];
  assign data_q              = pin_q[DATA_W-1:0];
  assign {ale_d, rd_d, wr_d, cs_d, a0_d} = pin_d[PIN_W-1 -: CTRL_PINS];
  assign data_d              = pin_d[DATA_W-1:0];

  hcp_phase_sel u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ale_q_i   (ale_q),
    .ale_d_i   (ale_d),
    .d0_q_i    (data_q[0]),
    .a0_d_i    (a0_d),
    .phase_o   (phase),
    .mux_mode_o(mux_mode)
  );

  hcp_strobe_dec #(
    .DATA_W(DATA_W)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_q_i   (wr_q),
    .wr_d_i   (wr_d),
    .rd_q_i   (rd_q),
    .rd_d_i   (rd_d),
    .cs_d_i   (cs_d),
    .phase_i  (phase),
    .data_d_i (data_d),
    .cmd_wr_o (cmd_wr_o),
    .data_wr_o(data_wr_o),
    .wr_byte_o(wr_byte_o),
    .data_rd_o(data_rd_o)
  );

  // pad enable follows the pins directly so read data meets host access time
  assign data_oe_o = !cs_ni && !rd_ni;
  assign data_o    = data_oe_o ? rd_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b1;
    else         int_q <= !irq_i;
  end
  assign int_no = int_q;
endmodule

// File: rtl/host_cmd_port_chk.sv
module host_cmd_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              irq_i,
  input logic              int_no,
  input logic              cmd_wr_o,
  input logic              data_wr_o,
  input logic              data_rd_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R2
  cmd_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |=> !cmd_wr_o);
  // R3
  data_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_o |=> !data_wr_o);
  // R1
  one_location_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_wr_o, data_wr_o}));
  // R6
  rd_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_o |=> !data_rd_o);
  // R11
  deselect_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);
  // R5
  read_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (data_o == rd_data_i));
  // R9
  int_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    int_no == !$past(irq_i));
endmodule

bind host_cmd_port host_cmd_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .data_oe_o(data_oe_o),
  .data_o   (data_o),
  .rd_data_i(rd_data_i),
  .irq_i    (irq_i),
  .int_no   (int_no),
  .cmd_wr_o (cmd_wr_o),
  .data_wr_o(data_wr_o),
  .data_rd_o(data_rd_o)
);

// File: tb/host_cmd_port_tb.sv
`timescale 1ns/1ps
module host_cmd_port_tb;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0, a0 = 1'b0, irq = 1'b0;
  logic [DW-1:0] din = '0, rdat = '0;
  logic [DW-1:0] dout, wbyte;
  logic oe, int_n, cmd_wr, data_wr, data_rd;

  int n_tests = 0, n_fail = 0;
  int n_cmd = 0, n_dwr = 0, n_drd = 0;
  logic [DW-1:0] last_byte = '0;
  bit done = 0;

  always #2 clk = ~clk;

  host_cmd_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .ale_i(ale), .a0_i(a0), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .rd_data_i(rdat), .irq_i(irq), .int_no(int_n), .cmd_wr_o(cmd_wr),
    .data_wr_o(data_wr), .wr_byte_o(wbyte), .data_rd_o(data_rd)
  );

  always @(posedge clk) begin
    if (cmd_wr)  begin n_cmd++; last_byte = wbyte; end
    if (data_wr) begin n_dwr++; last_byte = wbyte; end
    if (data_rd) n_drd++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [DW-1:0] b, input logic cs);
    @(negedge clk);
    a0 = sel; din = b; cs_n = !cs;
    idle(1); wr_n = 1'b0;
    idle(4); wr_n = 1'b1;
    din = ~b; cs_n = 1'b1; a0 = !sel;  // change right after the edge
    idle(6);
  endtask

  task automatic bus_read(input logic sel, input logic cs);
    @(negedge clk);
    a0 = sel; cs_n = !cs;
    idle(1); rd_n = 1'b0;
    idle(4); rd_n = 1'b1;
    cs_n = 1'b1; a0 = !sel;
    idle(6);
  endtask

  task automatic t_reset();
    idle(2);
    chk(int_n == 1'b1, "R10 int_no in reset", int_n, 1);
    chk(!cmd_wr && !data_wr && !data_rd, "R10 strobes in reset", {cmd_wr, data_wr, data_rd}, 0);
    chk(oe == 1'b0, "R10 oe in reset", oe, 0);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_cmd_write();
    int c0 = n_cmd, d0 = n_dwr;
    @(negedge clk);
    a0 = 1'b0; din = 8'h3C; cs_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(3); wr_n = 1'b1; din = 8'hFF; cs_n = 1'b1; a0 = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(cmd_wr == 1'b0, "R2 no pulse before third edge", cmd_wr, 0);
    @(posedge clk); #1;
    chk(cmd_wr == 1'b1, "R2 pulse on third edge", cmd_wr, 1);
    chk(wbyte == 8'h3C, "R2 command byte", wbyte, 8'h3C);
    idle(4);
    chk(n_cmd - c0 == 1, "R2 single command pulse", n_cmd - c0, 1);
    chk(n_dwr == d0, "R1 no data pulse for command", n_dwr - d0, 0);
  endtask

  task automatic t_data_write();
    int c0 = n_cmd, d0 = n_dwr;
    bus_write(1'b1, 8'hA7, 1'b1);
    chk(n_dwr - d0 == 1, "R3 single data pulse", n_dwr - d0, 1);
    chk(last_byte == 8'hA7, "R3 data byte", last_byte, 8'hA7);
    chk(n_cmd == c0, "R3 no command pulse", n_cmd - c0, 0);
    bus_write(1'b0, 8'h01, 1'b1);
    bus_write(1'b1, 8'h80, 1'b1);
    chk(n_cmd - c0 == 1 && n_dwr - d0 == 2, "R7 a0 selects phase",
        (n_cmd - c0) * 16 + (n_dwr - d0), 8'h12);
    chk(last_byte == 8'h80, "R7 byte after alternation", last_byte, 8'h80);
  endtask

  task automatic t_cs_high_write();
    int c0 = n_cmd, d0 = n_dwr;
    logic [DW-1:0] b0 = wbyte;
    bus_write(1'b0, 8'h55, 1'b0);
    bus_write(1'b1, 8'h66, 1'b0);
    chk(n_cmd == c0 && n_dwr == d0, "R4 deselected writes ignored",
        (n_cmd - c0) + (n_dwr - d0), 0);
    chk(wbyte == b0, "R4 byte unchanged", wbyte, b0);
  endtask

  task automatic t_read();
    int r0 = n_drd;
    rdat = 8'hC3;
    @(negedge clk); cs_n = 1'b0; a0 = 1'b1; rd_n = 1'b0; #1;
    chk(oe == 1'b1, "R5 oe during read", oe, 1);
    chk(dout == 8'hC3, "R5 read value", dout, 8'hC3);
    rdat = 8'h1E; #1;
    chk(dout == 8'h1E, "R5 read value follows core", dout, 8'h1E);
    idle(4); rd_n = 1'b1; #1;
    chk(oe == 1'b0, "R5 oe released", oe, 0);
    cs_n = 1'b1;
    idle(6);
    chk(n_drd - r0 == 1, "R6 data read pulse", n_drd - r0, 1);
    bus_read(1'b0, 1'b1);
    chk(n_drd - r0 == 1, "R6 command read gives no pulse", n_drd - r0, 1);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(oe == 1'b0, "R11 no drive while deselected", oe, 0);
    idle(4); rd_n = 1'b1;
    idle(6);
    chk(n_drd - r0 == 1, "R11 deselected read gives no pulse", n_drd - r0, 1);
  endtask

  task automatic t_irq();
    @(negedge clk); irq = 1'b1;
    @(posedge clk); #1;
    chk(int_n == 1'b0, "R9 interrupt asserted", int_n, 0);
    @(negedge clk); irq = 1'b0;
    #1 chk(int_n == 1'b0, "R9 held until edge", int_n, 0);
    @(posedge clk); #1;
    chk(int_n == 1'b1, "R9 interrupt released", int_n, 1);
  endtask

  task automatic mux_write(input logic [DW-1:0] addr, input logic pin_a0, input logic [DW-1:0] b);
    @(negedge clk);
    a0 = pin_a0; din = addr; ale = 1'b1;
    idle(3); ale = 1'b0;
    idle(4);
    din = b; cs_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(4); wr_n = 1'b1; cs_n = 1'b1; din = 8'h00;
    idle(6);
  endtask

  task automatic t_mux();
    int c0 = n_cmd, d0 = n_dwr;
    mux_write(8'h01, 1'b0, 8'h5C);
    chk(n_dwr - d0 == 1 && n_cmd == c0, "R8 address bit0=1 selects data",
        (n_cmd - c0) * 16 + (n_dwr - d0), 1);
    chk(last_byte == 8'h5C, "R8 mux data byte", last_byte, 8'h5C);
    mux_write(8'hFE, 1'b1, 8'h9A);
    chk(n_cmd - c0 == 1 && n_dwr - d0 == 1, "R8 address bit0=0 selects command",
        (n_cmd - c0) * 16 + (n_dwr - d0), 8'h11);
    chk(last_byte == 8'h9A, "R8 mux command byte", last_byte, 8'h9A);
  endtask

  initial begin
    t_reset();
    t_cmd_write();
    t_data_write();
    t_cs_high_write();
    t_read();
    t_irq();
    t_mux();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule